// File: doc/BRIEF.md
# Counted Serial Shift Engine

This block is the data path of a synchronous serial port. A single shift register, 8 or 16 bits wide, sends one bit and captures one bit for every serial clock period. A bit counter limits how many bits one transfer moves. Software loads the data word and the bit count through simple write strobes. Once the count is written, the block uses edge strobes supplied from outside. Each strobe marks one edge of the serial clock. From these strobes the block forms the serial clock level with the selected polarity.

The counter also controls the completion flag. Loading a nonzero count clears the flag and starts a transfer. When the count reaches zero, the flag is set and any further edge strobes are ignored, so no clock is consumed past the last bit. An enable decides whether the flag drives the interrupt request. Software can also clear the flag directly, or reset the whole engine synchronously.

Top module: `shift_engine`

## Requirements
- R1: With `wide_i`=1 all 16 bits shift. With `wide_i`=0 only bits 7:0 shift, and bits 15:8 keep their value.
- R2: With `lsb_first_i`=0, bits leave from the top bit (15, or 7 when narrow) and enter at bit 0. With `lsb_first_i`=1, bits leave from bit 0 and enter at the top bit. The same order applies to send and receive.
- R3: Each bit period of two edge strobes sends one bit on `sdo_o` and captures one bit from `sdi_i`. After n bits the register holds the remaining transmit bits together with the n received bits.
- R4: The counter drops by one at the second edge of each bit. `done_o` rises in the cycle the count reaches zero. Writing a count of zero also sets `done_o` one cycle after the write.
- R5: Writing a nonzero count clears `done_o`, unless `auto_clr_dis_i`=1. In that case `done_o` keeps its value.
- R6: While `done_o`=1, edge strobes have no effect. The data, the count and `sclk_o` stay unchanged.
- R7: `sclk_o` rests at `cpol_i` between bits. It is inverted between the first and second edge of a bit.
- R8: With `cpha_i`=0, the first bit is on `sdo_o` before the first edge, and input is sampled on the first edge of each bit. With `cpha_i`=1, `sdo_o` changes on the first edge, and input is sampled on the second edge.
- R9: With `out_en_i`=0, `sdo_oe_o`=0 and `sdo_o`=0. With `out_en_i`=1, `sdo_oe_o`=1 and `sdo_o` carries the current send bit.
- R10: `irq_o` is `done_o` gated by `irq_en_i`. A `flag_clr_i` pulse clears `done_o`.
- R11: After `rst_ni` or a `soft_rst_i` pulse, the data, the count and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous engine reset |
| wide_i | input | 1 | 1: 16-bit shift, 0: 8-bit shift |
| lsb_first_i | input | 1 | Bit order select |
| cpol_i | input | 1 | Idle serial clock level |
| cpha_i | input | 1 | Phase select |
| out_en_i | input | 1 | Serial output enable |
| irq_en_i | input | 1 | Interrupt enable for the completion flag |
| auto_clr_dis_i | input | 1 | Stops a count write from clearing the flag |
| data_we_i | input | 1 | Data word write strobe |
| data_wdata_i | input | 16 | Data word to load |
| data_rdata_o | output | 16 | Current shift register |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 5 | Count to load |
| cnt_o | output | 5 | Current count |
| flag_clr_i | input | 1 | Direct completion flag clear |
| edge_i | input | 1 | One strobe per serial clock edge |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial output drive enable |
| sclk_o | output | 1 | Serial clock level |
| done_o | output | 1 | Transfer complete flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take some things for granted about the inputs:
- `cpol_i` is not changed while the flag is held.
- A count write and a soft reset are the only ways the count moves other than a bit completion.
- `sdi_i` is stable at the edge strobe that samples it.

The stimulus follows these rules:
- It drives every input on the falling clock edge.
- It changes the configuration only between transfers.
- It sets the serial input one strobe before the edge that uses it and holds it through both edges of the bit.
- It never overlaps a data write or count write with an edge strobe.

// File: rtl/shift_engine_pkg.sv
package shift_engine_pkg;
  typedef struct packed {
    logic wide;
    logic lsb_first;
    logic cpol;
    logic cpha;
  } shift_cfg_t;
endpackage

// File: rtl/sse_bit_counter.sv
module sse_bit_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             auto_clr_dis_i,
  input  logic             flag_clr_i,
  input  logic             bit_done_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_bit;

  assign last_bit = bit_done_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (soft_rst_i)      cnt_q <= '0;
    else if (cnt_we_i)        cnt_q <= cnt_wdata_i;
    else if (bit_done_i)      cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         done_q <= 1'b0;
    else if (soft_rst_i)                 done_q <= 1'b0;
    else if (cnt_we_i) begin
      if (cnt_wdata_i == '0)             done_q <= 1'b1;
      else if (!auto_clr_dis_i)          done_q <= 1'b0;
      else if (flag_clr_i)               done_q <= 1'b0;
    end
    else if (last_bit)                   done_q <= 1'b1;
    else if (flag_clr_i)                 done_q <= 1'b0;
  end

  assign cnt_o    = cnt_q;
  assign done_o   = done_q;
  assign active_o = !done_q && (cnt_q != '0);

  // R4
  decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_done_i && !cnt_we_i && !soft_rst_i |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4
  zero_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i && (cnt_wdata_i == '0) && !soft_rst_i |=> done_q);
  // R5
  auto_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i && (cnt_wdata_i != '0) && !auto_clr_dis_i && !soft_rst_i |=> !done_q);
endmodule

// File: rtl/sse_clk_phase.sv
module sse_clk_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic restart_i,
  input  logic edge_ok_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic sdi_i,
  input  logic tx_bit_i,
  output logic sclk_o,
  output logic trail_o,
  output logic rx_bit_o,
  output logic sdo_bit_o
);
  logic half_q;
  logic sample_q;
  logic sdo_q;
  logic lead;

  assign lead    = edge_ok_i && !half_q;
  assign trail_o = edge_ok_i &&  half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q   <= 1'b0;
      sample_q <= 1'b0;
      sdo_q    <= 1'b0;
    end else if (soft_rst_i) begin
      half_q   <= 1'b0;
      sample_q <= 1'b0;
      sdo_q    <= 1'b0;
    end else begin
      if (restart_i)      half_q <= 1'b0;
      else if (edge_ok_i) half_q <= !half_q;
      if (lead) begin
        sample_q <= sdi_i;     // used when sampling leads
        sdo_q    <= tx_bit_i;  // used when output change leads
      end
    end
  end

  assign sclk_o    = cpol_i ^ half_q;
  assign rx_bit_o  = cpha_i ? sdi_i : sample_q;
  assign sdo_bit_o = cpha_i ? sdo_q : tx_bit_i;
endmodule

// File: rtl/sse_shift_reg.sv
module sse_shift_reg #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              shift_i,
  input  logic              rx_bit_i,
  input  logic              wide_i,
  input  logic              lsb_first_i,
  output logic [DATA_W-1:0] data_o,
  output logic              tx_bit_o
);
  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] up_wide, dn_wide, up_narrow, dn_narrow, shifted;

  assign up_wide   = {sr_q[DATA_W-2:0], rx_bit_i};
  assign dn_wide   = {rx_bit_i, sr_q[DATA_W-1:1]};
  assign up_narrow = {sr_q[DATA_W-1:NARROW_W], sr_q[NARROW_W-2:0], rx_bit_i};
  assign dn_narrow = {sr_q[DATA_W-1:NARROW_W], rx_bit_i, sr_q[NARROW_W-1:1]};

  always_comb begin
    unique case ({wide_i, lsb_first_i})
      2'b10:   shifted = up_wide;
      2'b11:   shifted = dn_wide;
      2'b00:   shifted = up_narrow;
      default: shifted = dn_narrow;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (soft_rst_i) sr_q <= '0;
    else if (wr_i)       sr_q <= wdata_i;
    else if (shift_i)    sr_q <= shifted;
  end

  always_comb begin
    if (lsb_first_i) tx_bit_o = sr_q[0];
    else if (wide_i) tx_bit_o = sr_q[DATA_W-1];
    else             tx_bit_o = sr_q[NARROW_W-1];
  end

  assign data_o = sr_q;

  // R1
  narrow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !wide_i && !wr_i && !soft_rst_i
      |=> data_o[DATA_W-1:NARROW_W] == $past(data_o[DATA_W-1:NARROW_W]));
endmodule

// File: rtl/shift_engine.sv
module shift_engine
  import shift_engine_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wide_i,
  input  logic              lsb_first_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              out_en_i,
  input  logic              irq_en_i,
  input  logic              auto_clr_dis_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output logic [DATA_W-1:0] data_rdata_o,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  input  logic              flag_clr_i,
  input  logic              edge_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sclk_o,
  output logic              done_o,
  output logic              irq_o
);
  shift_cfg_t cfg;
  logic active, edge_ok, trail, rx_bit, tx_bit, sdo_bit;

  assign cfg = '{wide: wide_i, lsb_first: lsb_first_i, cpol: cpol_i, cpha: cpha_i};

  // writes win over a same-cycle edge
  assign edge_ok = edge_i && active && !cnt_we_i && !data_we_i && !soft_rst_i;

  sse_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .soft_rst_i,
    .cnt_we_i, .cnt_wdata_i, .auto_clr_dis_i, .flag_clr_i,
    .bit_done_i (trail),
    .cnt_o, .done_o,
    .active_o   (active)
  );

  sse_clk_phase u_phase (
    .clk_i, .rst_ni, .soft_rst_i,
    .restart_i (cnt_we_i),
    .edge_ok_i (edge_ok),
    .cpol_i    (cfg.cpol),
    .cpha_i    (cfg.cpha),
    .sdi_i,
    .tx_bit_i  (tx_bit),
    .sclk_o,
    .trail_o   (trail),
    .rx_bit_o  (rx_bit),
    .sdo_bit_o (sdo_bit)
  );

  sse_shift_reg #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_sr (
    .clk_i, .rst_ni, .soft_rst_i,
    .wr_i        (data_we_i),
    .wdata_i     (data_wdata_i),
    .shift_i     (trail),
    .rx_bit_i    (rx_bit),
    .wide_i      (cfg.wide),
    .lsb_first_i (cfg.lsb_first),
    .data_o      (data_rdata_o),
    .tx_bit_o    (tx_bit)
  );

  assign sdo_oe_o = out_en_i;
  assign sdo_o    = out_en_i & sdo_bit;
  assign irq_o    = irq_en_i & done_o;

  // R6
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !data_we_i && !soft_rst_i |=> $stable(data_rdata_o));
  // R7
  idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sclk_o == cpol_i);
  // R4
  flag_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cnt_o == '0);
  // R11
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (cnt_o == '0) && !done_o && (data_rdata_o == '0));
endmodule

// File: tb/shift_engine_test.sv
module shift_engine_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wide, lsb, cpha, cpol;
    logic [15:0] tx, rx;
    logic [4:0]  n;
    logic [15:0] expect_w;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'hA5C3, 16'h1234, 5'd4,  16'h5C31},
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'hA5C3, 16'h1234, 5'd4,  16'h4A5C},
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'hA5C3, 16'h12E0, 5'd3,  16'hA51F},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h3C96, 16'hFF0B, 5'd5,  16'h3C5C},
    '{1'b1, 1'b0, 1'b1, 1'b1, 16'h8001, 16'h7E5A, 5'd16, 16'h7E5A},
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'h1234, 16'hABCD, 5'd8,  16'h12CD}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, wide = 1, lsb = 0, cpol = 0, cpha = 0, oe = 1, irq_en = 0, clr_dis = 0;
  logic data_we = 0, cnt_we = 0, flag_clr = 0, edge_s = 0, sdi = 0;
  logic [15:0] wdata = '0, rdata;
  logic [4:0]  cwdata = '0, cnt;
  logic sdo, sdo_oe, sclk, done, irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .wide_i(wide), .lsb_first_i(lsb),
    .cpol_i(cpol), .cpha_i(cpha), .out_en_i(oe), .irq_en_i(irq_en), .auto_clr_dis_i(clr_dis),
    .data_we_i(data_we), .data_wdata_i(wdata), .data_rdata_o(rdata),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cwdata), .cnt_o(cnt), .flag_clr_i(flag_clr),
    .edge_i(edge_s), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sclk_o(sclk),
    .done_o(done), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr_data(input logic [15:0] v);
    wdata = v; data_we = 1; @(negedge clk); data_we = 0;
  endtask
  task automatic wr_cnt(input logic [4:0] v);
    cwdata = v; cnt_we = 1; @(negedge clk); cnt_we = 0;
  endtask
  task automatic pulse_edge();
    edge_s = 1; @(negedge clk); edge_s = 0;
  endtask
  task automatic pulse_clr();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  // runs n bits, returns counts of sdo and mid-bit sclk mismatches
  task automatic run_bits(input int n, input logic [15:0] tx, input logic [15:0] rx,
                          output int sdo_bad, output int clk_bad);
    int top;
    top = wide ? 15 : 7;
    sdo_bad = 0; clk_bad = 0;
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = lsb ? k : top - k;
      sdi = rx[idx];
      if (!cpha && sdo !== tx[idx]) sdo_bad++;
      pulse_edge();
      if (cpha && sdo !== tx[idx]) sdo_bad++;
      if (sclk !== ~cpol) clk_bad++;
      pulse_edge();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int sb, cb;
    repeat (3) @(negedge clk);
    // R11 reset state, R7 idle level
    check("R11 data after reset", rdata, 0);
    check("R11 count after reset", cnt, 0);
    check("R11 flag after reset", done, 0);
    check("R7 idle sclk", sclk, 0);
    rst_n = 1; @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wide = VEC[v].wide; lsb = VEC[v].lsb; cpha = VEC[v].cpha; cpol = VEC[v].cpol;
      @(negedge clk);
      wr_data(VEC[v].tx);
      wr_cnt(VEC[v].n);
      check("R5 flag cleared by count load", done, 0);
      run_bits(VEC[v].n, VEC[v].tx, VEC[v].rx, sb, cb);
      check("R1 R2 R3 received word", rdata, VEC[v].expect_w);
      check("R2 R8 sdo bit stream mismatches", sb, 0);
      check("R7 mid-bit sclk mismatches", cb, 0);
      check("R4 flag at end", done, 1);
      check("R4 count at end", cnt, 0);
      check("R7 sclk idle after transfer", sclk, cpol);
    end

    // R9 output enable
    wide = 1; lsb = 0; cpha = 0; cpol = 0; @(negedge clk);
    wr_data(16'hFFFF);
    oe = 0; @(negedge clk);
    check("R9 sdo_oe off", sdo_oe, 0);
    check("R9 sdo released", sdo, 0);
    oe = 1; @(negedge clk);
    check("R9 sdo_oe on", sdo_oe, 1);
    check("R9 sdo drives bit", sdo, 1);

    // R4 zero write, R10 irq gating
    pulse_clr();
    check("R10 flag cleared directly", done, 0);
    wr_cnt(5'd0);
    check("R4 zero write sets flag", done, 1);
    check("R10 irq masked", irq, 0);
    irq_en = 1; @(negedge clk);
    check("R10 irq enabled", irq, 1);

    // R5 auto-clear disabled, R6 frozen
    clr_dis = 1;
    wr_data(16'h00F0);
    wr_cnt(5'd3);
    check("R5 flag kept with clear disabled", done, 1);
    check("R5 count loaded", cnt, 3);
    for (int i = 0; i < 4; i++) pulse_edge();
    check("R6 data frozen", rdata, 16'h00F0);
    check("R6 count frozen", cnt, 3);
    check("R6 sclk frozen", sclk, cpol);
    pulse_clr();
    check("R10 flag cleared by pulse", done, 0);
    check("R10 irq follows flag", irq, 0);
    clr_dis = 0;
    run_bits(3, 16'h00F0, 16'hFFFF, sb, cb);
    check("R3 R4 three-bit result", rdata, 16'h0787);
    check("R4 flag after count down", done, 1);
    check("R10 irq raised", irq, 1);
    pulse_edge(); pulse_edge();
    check("R6 extra edges ignored", rdata, 16'h0787);
    wr_cnt(5'd2);
    check("R5 nonzero write clears flag", done, 0);

    // R11 soft reset
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    check("R11 soft reset data", rdata, 0);
    check("R11 soft reset count", cnt, 0);
    check("R11 soft reset flag", done, 0);

    summary();
  end
endmodule